// File: doc/BRIEF.md
# Clock Output Stop and Test Control

This block sits between the internally generated clock sources of a desktop clock generator and its output pins. It gates eight output clock groups: CPU, stoppable PCI, free-running PCI, SDRAM, reference, IOAPIC, USB and AGP. It applies the CPU-stop, PCI-stop and power-down pins, drives the oscillator and PLL enables, and supports two alternate modes. In the first, every output is released to high impedance. In the second, every output carries a division of an external test clock.

All logic runs on one fast sampling clock `clk`. Each source clock is presented on `srcClk` as a level that is sampled on that clock. Every output is registered, so a clock output follows its source one cycle late. Gating is applied only while a source is low. As a result a stop or restart never trims a high phase.

Top module: `clkctl_top`

## Requirements
- R1: Output group indices are 0 CPU, 1 PCI, 2 free-running PCI, 3 SDRAM, 4 reference, 5 IOAPIC, 6 USB, 7 AGP. In normal mode (`cfgMode` 2'b00 or 2'b10), once powered up and with no stop asserted, `clkOut[i]` equals `srcClk[i]` as sampled at the previous rising edge of `clk`.
- R2: `cpuStopN`, `pciStopN` and `pwrDownN` pass through `SYNC_STAGES` flops before use. All three are ignored while `modeSel` is high.
- R3: `pwrDownN` low (with `modeSel` low) drops `oscEn` and `pllEn`. Every output then settles low.
- R4: On power-up, `oscEn` rises first and `pllEn` rises one cycle later. `pllEn` is never high while `oscEn` is low. Outputs may start toggling only after `PWRUP_CYC` powered cycles. In reset all outputs, enables and `oscEn` are 0.
- R5: `cpuStopN` low stops only `clkOut[0]`. All other groups keep running.
- R6: `pciStopN` low stops `clkOut[1]`. `clkOut[2]` (free-running PCI) keeps running.
- R7: Stops, restarts and power-down take effect only while the source is low. In normal mode every high pulse on `clkOut[i]` is as long as the source's high phase.
- R8: With `cfgMode` 2'b11, every `clkOe` bit and every `clkOut` bit is 0 one cycle later. In any other mode `clkOe` is all ones.
- R9: With `cfgMode` 2'b01 (test), the outputs carry the test clock instead of the sources, and the stop and power-down pins are ignored. Groups 4 and 5 carry the test clock itself. Groups 0, 3, 6 and 7 carry the test clock divided by 2. Groups 1 and 2 carry it divided by 4.
- R10: The test dividers are cleared whenever test mode is not selected. After entry, the first test-clock rising edge drives all divide-by-2 outputs high together while the divide-by-4 outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rstN | input | 1 | Asynchronous reset, active low |
| srcClk | input | 8 | Source clock levels, one per group |
| testClk | input | 1 | External test clock |
| modeSel | input | 1 | High disables the stop and power-down pins |
| cpuStopN | input | 1 | Low stops the CPU group |
| pciStopN | input | 1 | Low stops the stoppable PCI group |
| pwrDownN | input | 1 | Low powers the generator down |
| cfgMode | input | 2 | 00/10 normal, 01 test, 11 high impedance |
| clkOut | output | 8 | Gated or test clock outputs |
| clkOe | output | 8 | Output enables, one per group |
| oscEn | output | 1 | Oscillator enable |
| pllEn | output | 1 | PLL enable |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `PWRUP_CYC` = 5, both above the defaults. These values make the synchroniser delay and the power-up wait long enough to be told apart from off-by-one latencies. Each source runs at its own half period (2 to 9 cycles), so a stop that lands mid-pulse on one group lands on a low phase of another. The test clock has a half period of 3 cycles, which lets the bench measure the 1, 2 and 4 division ratios against each other.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int NUM_GRP = 8;

  localparam int GRP_CPU   = 0;
  localparam int GRP_PCI   = 1;
  localparam int GRP_PCIF  = 2;
  localparam int GRP_SDRAM = 3;
  localparam int GRP_REF   = 4;
  localparam int GRP_APIC  = 5;
  localparam int GRP_USB   = 6;
  localparam int GRP_AGP   = 7;

  localparam logic [1:0] MODE_TEST = 2'b01;
  localparam logic [1:0] MODE_HIZ  = 2'b11;

  localparam int TDIV_W = 2;

  // test-clock tap per group: 0 = undivided, 1 = half, 2 = quarter
  function automatic int groupTap(input int g);
    case (g)
      GRP_REF, GRP_APIC: return 0;
      GRP_PCI, GRP_PCIF: return 2;
      default:           return 1;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_GRP-1:0] runReq;
    logic               testMode;
    logic               hiZ;
  } ctlStrobe_t;

endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '1;
    else       shiftQ <= {shiftQ[STAGES-2:0], din};
  end

  assign dout = shiftQ[STAGES-1];

endmodule

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PWRUP_CYC   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       cpuStopN,
  input  logic       pciStopN,
  input  logic       pwrDownN,
  input  logic [1:0] cfgMode,
  output ctlStrobe_t strobe,
  output logic       oscEn,
  output logic       pllEn
);

  localparam int CNT_W = $clog2(PWRUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PWRUP_CYC);

  logic [2:0] pinRaw;
  logic [2:0] pinSync;
  logic       cpuHold, pciHold, pdHold, ready;
  logic [CNT_W-1:0] pwrCnt;

  assign pinRaw = {pwrDownN, pciStopN, cpuStopN};

  generate
    for (genvar g = 0; g < 3; g++) begin : g_sync
      clkctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rstN (rstN),
        .din  (pinRaw[g]),
        .dout (pinSync[g])
      );
    end
  endgenerate

  assign cpuHold = ~modeSel & ~pinSync[0];
  assign pciHold = ~modeSel & ~pinSync[1];
  assign pdHold  = ~modeSel & ~pinSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscEn  <= 1'b0;
      pllEn  <= 1'b0;
      pwrCnt <= '0;
    end else begin
      oscEn <= ~pdHold;
      pllEn <= oscEn & ~pdHold;
      if (pdHold)                pwrCnt <= '0;
      else if (pwrCnt != CNT_TOP) pwrCnt <= pwrCnt + 1'b1;
    end
  end

  assign ready = (pwrCnt == CNT_TOP);

  always_comb begin
    strobe.testMode = (cfgMode == MODE_TEST);
    strobe.hiZ      = (cfgMode == MODE_HIZ);
    strobe.runReq   = {NUM_GRP{ready}};
    if (cpuHold) strobe.runReq[GRP_CPU] = 1'b0;
    if (pciHold) strobe.runReq[GRP_PCI] = 1'b0;
  end

endmodule

// File: rtl/clkctl_dp.sv
module clkctl_dp
  import clkctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GRP-1:0] srcClk,
  input  logic               testClk,
  input  ctlStrobe_t         strobe,
  output logic [NUM_GRP-1:0] clkOut,
  output logic [NUM_GRP-1:0] clkOe
);

  logic              tReg, tPrev;
  logic [TDIV_W-1:0] tDiv;
  logic [NUM_GRP-1:0] gateEn;
  logic [NUM_GRP-1:0] testBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tReg  <= 1'b0;
      tPrev <= 1'b0;
      tDiv  <= '0;
    end else begin
      tReg  <= testClk;
      tPrev <= tReg;
      if (!strobe.testMode)   tDiv <= '0;
      else if (tReg && !tPrev) tDiv <= tDiv + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      // gate changes only during the low phase of its source
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          gateEn[g] <= 1'b0;
        else if (!srcClk[g]) gateEn[g] <= strobe.runReq[g];
      end

      if (groupTap(g) == 0) begin : g_tap1
        assign testBit[g] = tReg;
      end else if (groupTap(g) == 1) begin : g_tap2
        assign testBit[g] = tDiv[0];
      end else begin : g_tap4
        assign testBit[g] = tDiv[1];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkOut[g] <= 1'b0;
          clkOe[g]  <= 1'b0;
        end else begin
          clkOe[g] <= ~strobe.hiZ;
          if (strobe.hiZ)           clkOut[g] <= 1'b0;
          else if (strobe.testMode) clkOut[g] <= testBit[g];
          else                      clkOut[g] <= srcClk[g] & gateEn[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PWRUP_CYC   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] srcClk,
  input  logic       testClk,
  input  logic       modeSel,
  input  logic       cpuStopN,
  input  logic       pciStopN,
  input  logic       pwrDownN,
  input  logic [1:0] cfgMode,
  output logic [7:0] clkOut,
  output logic [7:0] clkOe,
  output logic       oscEn,
  output logic       pllEn
);

  ctlStrobe_t strobe;

  clkctl_ctrl #(.SYNC_STAGES(SYNC_STAGES), .PWRUP_CYC(PWRUP_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .cpuStopN (cpuStopN),
    .pciStopN (pciStopN),
    .pwrDownN (pwrDownN),
    .cfgMode  (cfgMode),
    .strobe   (strobe),
    .oscEn    (oscEn),
    .pllEn    (pllEn)
  );

  clkctl_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcClk  (srcClk),
    .testClk (testClk),
    .strobe  (strobe),
    .clkOut  (clkOut),
    .clkOe   (clkOe)
  );

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cfgMode,
  input logic [7:0] srcClk,
  input logic [7:0] clkOut,
  input logic [7:0] clkOe,
  input logic       oscEn,
  input logic       pllEn
);

  p_hiz_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgMode) == 2'b11) |-> (clkOe == 8'h00 && clkOut == 8'h00));

  p_oe_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgMode) != 2'b11) |-> (clkOe == 8'hFF));

  p_pll_after_osc_r4: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> oscEn);

  p_test_div_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(cfgMode) == 2'b01 && $past(cfgMode, 2) == 2'b01
     && clkOut[1] != $past(clkOut[1]))
    |-> ($past(clkOut[0]) && !clkOut[0]));

  generate
    for (genvar i = 0; i < 8; i++) begin : g_pulse
      p_full_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN, 2) && !$past(cfgMode[0]) && !$past(cfgMode[0], 2)
         && $fell(clkOut[i])) |-> !$past(srcClk[i]));
    end
  endgenerate

endmodule

bind clkctl_top clkctl_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgMode (cfgMode),
  .srcClk  (srcClk),
  .clkOut  (clkOut),
  .clkOe   (clkOe),
  .oscEn   (oscEn),
  .pllEn   (pllEn)
);

// File: tb/tb_clkctl_top.sv
`timescale 1ns/1ps
module tb_clkctl_top;

  localparam int SYNC = 3;
  localparam int PWRUP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] srcClk = 8'h00;
  logic testClk = 1'b0;
  logic modeSel = 1'b0, cpuStopN = 1'b1, pciStopN = 1'b1, pwrDownN = 1'b1;
  logic [1:0] cfgMode = 2'b00;
  logic [7:0] clkOut, clkOe;
  logic oscEn, pllEn;

  int checks = 0, errors = 0;
  bit done = 0;
  bit monOn = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  clkctl_top #(.SYNC_STAGES(SYNC), .PWRUP_CYC(PWRUP)) dut (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .testClk(testClk),
    .modeSel(modeSel), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .pwrDownN(pwrDownN), .cfgMode(cfgMode), .clkOut(clkOut),
    .clkOe(clkOe), .oscEn(oscEn), .pllEn(pllEn)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus sources: group i has half period i+2, test clock half period 3
  int hc[8] = '{default: 0};
  int tc = 0;
  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (hc[i] == i + 1) begin hc[i] = 0; srcClk[i] = ~srcClk[i]; end
      else hc[i]++;
    end
    if (tc == 2) begin tc = 0; testClk = ~testClk; end
    else tc++;
  end

  // behavioural reference model
  bit mEn[8];
  logic [7:0] mOut = 0, mOe = 0;
  bit mOsc = 0, mPll = 0, mT = 0, mTp = 0;
  int mCnt = 0, mDiv = 0;
  bit qCpu[$], qPci[$], qPd[$];
  logic [7:0] srcPrev = 0;

  always @(posedge clk) begin
    srcPrev <= srcClk;
    if (!rstN) begin
      foreach (mEn[i]) mEn[i] = 0;
      mOut = 0; mOe = 0; mOsc = 0; mPll = 0; mT = 0; mTp = 0;
      mCnt = 0; mDiv = 0;
      qCpu.delete(); qPci.delete(); qPd.delete();
      for (int k = 0; k < SYNC; k++) begin
        qCpu.push_back(1); qPci.push_back(1); qPd.push_back(1);
      end
    end else begin
      bit c, p, d, pdE, cs, ps, ready, tm, hz;
      logic [7:0] nOut;
      c = qCpu.pop_front(); p = qPci.pop_front(); d = qPd.pop_front();
      qCpu.push_back(cpuStopN); qPci.push_back(pciStopN); qPd.push_back(pwrDownN);
      pdE = !modeSel && !d;
      cs  = !modeSel && !c;
      ps  = !modeSel && !p;
      ready = (mCnt == PWRUP);
      tm = (cfgMode == 2'b01);
      hz = (cfgMode == 2'b11);
      for (int i = 0; i < 8; i++) begin
        if (hz) nOut[i] = 0;
        else if (tm) begin
          if (i == 4 || i == 5)      nOut[i] = mT;
          else if (i == 1 || i == 2) nOut[i] = (mDiv / 2) % 2;
          else                       nOut[i] = mDiv % 2;
        end else nOut[i] = srcClk[i] & mEn[i];
      end
      for (int i = 0; i < 8; i++)
        if (!srcClk[i]) mEn[i] = ready && !(i == 0 && cs) && !(i == 1 && ps);
      mOut = nOut;
      mOe  = hz ? 8'h00 : 8'hFF;
      mPll = mOsc && !pdE;
      mOsc = !pdE;
      if (pdE) mCnt = 0; else if (mCnt != PWRUP) mCnt++;
      if (!tm) mDiv = 0; else if (mT && !mTp) mDiv = (mDiv + 1) % 4;
      mTp = mT;
      mT  = testClk;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(clkOut == mOut, {curReq, " clkOut"}, clkOut, mOut);
      chk(clkOe == mOe,   {curReq, " clkOe"},  clkOe,  mOe);
      chk(oscEn == mOsc,  {curReq, " oscEn"},  oscEn,  mOsc);
      chk(pllEn == mPll,  {curReq, " pllEn"},  pllEn,  mPll);
    end
  end

  // R7: high pulses in normal mode must have the full source width
  int runLen[8] = '{default: 0};
  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!monOn) runLen[i] = 0;
      else if (clkOut[i]) runLen[i]++;
      else if (runLen[i] > 0) begin
        chk(runLen[i] == i + 2, "R7 pulse width", runLen[i], i + 2);
        runLen[i] = 0;
      end
    end
  end

  task automatic countRises(input int n, output int r[8]);
    logic [7:0] prev;
    prev = clkOut;
    for (int i = 0; i < 8; i++) r[i] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) if (clkOut[i] && !prev[i]) r[i]++;
      prev = clkOut;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int r[8];
    int guard;
    repeat (3) @(negedge clk);
    chk(clkOut == 8'h00, "R4 reset clkOut", clkOut, 0);
    chk(clkOe == 8'h00, "R4 reset clkOe", clkOe, 0);
    chk(oscEn == 0 && pllEn == 0, "R4 reset enables", {oscEn, pllEn}, 0);
    rstN = 1'b1;
    monOn = 1;

    curReq = "R1";
    repeat (40) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk(clkOut == srcPrev, "R1 follow source", clkOut, srcPrev);
      @(negedge clk);
    end

    curReq = "R5";
    cpuStopN = 1'b0;
    repeat (20) @(negedge clk);
    countRises(30, r);
    chk(r[0] == 0, "R5 cpu stopped", r[0], 0);
    chk(r[3] > 0 && r[1] > 0, "R5 others run", {r[3][15:0], r[1][15:0]}, 1);
    cpuStopN = 1'b1;
    repeat (30) @(negedge clk);

    curReq = "R6";
    pciStopN = 1'b0;
    repeat (20) @(negedge clk);
    countRises(30, r);
    chk(r[1] == 0, "R6 pci stopped", r[1], 0);
    chk(r[2] > 0, "R6 free pci runs", r[2], 1);
    pciStopN = 1'b1;
    repeat (30) @(negedge clk);

    curReq = "R2";
    modeSel = 1'b1; pwrDownN = 1'b0; cpuStopN = 1'b0;
    repeat (30) @(negedge clk);
    chk(oscEn == 1, "R2 pins ignored oscEn", oscEn, 1);
    countRises(20, r);
    chk(r[0] > 0, "R2 pins ignored cpu", r[0], 1);
    cpuStopN = 1'b1;

    curReq = "R3";
    modeSel = 1'b0;
    repeat (40) @(negedge clk);
    chk(oscEn == 0 && pllEn == 0, "R3 enables off", {oscEn, pllEn}, 0);
    chk(clkOut == 8'h00, "R3 outputs low", clkOut, 0);

    curReq = "R4";
    pwrDownN = 1'b1;
    guard = 0;
    while (!oscEn && guard < 50) begin @(negedge clk); guard++; end
    chk(oscEn && !pllEn, "R4 osc before pll", {oscEn, pllEn}, 2'b10);
    @(negedge clk);
    chk(pllEn == 1, "R4 pll follows", pllEn, 1);
    chk(clkOut == 8'h00, "R4 outputs wait", clkOut, 0);
    repeat (40) @(negedge clk);
    monOn = 0;

    curReq = "R8";
    cfgMode = 2'b11;
    repeat (3) @(negedge clk);
    chk(clkOe == 8'h00, "R8 all disabled", clkOe, 0);
    repeat (10) @(negedge clk);

    curReq = "R9";
    cfgMode = 2'b01; pwrDownN = 1'b0; cpuStopN = 1'b0; pciStopN = 1'b0;
    repeat (6) @(negedge clk);
    countRises(96, r);
    chk(r[0] >= 7 && r[0] <= 9, "R9 half rate", r[0], 8);
    chk((r[0] - 2 * r[1]) <= 2 && (2 * r[1] - r[0]) <= 2, "R9 quarter rate", r[1], r[0] / 2);
    chk((r[4] - 2 * r[0]) <= 2 && (2 * r[0] - r[4]) <= 2, "R9 full rate", r[4], 2 * r[0]);
    chk(clkOe == 8'hFF, "R9 outputs enabled", clkOe, 8'hFF);

    curReq = "R10";
    cfgMode = 2'b00; pwrDownN = 1'b1; cpuStopN = 1'b1; pciStopN = 1'b1;
    repeat (7) @(negedge clk);
    cfgMode = 2'b01;
    guard = 0;
    while (!clkOut[0] && guard < 30) begin @(negedge clk); guard++; end
    chk(clkOut[0] && clkOut[3] && clkOut[6] && clkOut[7], "R10 halves in phase",
        clkOut, 8'hC9);
    chk(!clkOut[1] && !clkOut[2], "R10 quarters low", clkOut[2:1], 0);
    repeat (30) @(negedge clk);

    curReq = "R1";
    cfgMode = 2'b10;
    repeat (40) @(negedge clk);
    finishRun();
  end

endmodule